// File: doc/BRIEF.md
# Countdown Timer with Level and Pulsed Interrupts

The block is a programmable down-counter that measures periods in units of a selectable, free-running source tick. Software stores a count value n, picks one of several source tick lines, and enables the timer. Counting does not begin at the enabling write. It begins at the next 64 Hz alignment tick. Because the source tick is not aligned to that start, the first period lies between (n-1) and n source periods, plus up to one 64 Hz tick. Every later period is exactly n source ticks long, because the counter reloads itself at each terminal count.

Each terminal count sets a sticky timer flag that only an explicit software clear removes. When interrupts are enabled, the active-high interrupt line works in one of two modes, chosen by a mode bit. In level mode the line follows the flag. In pulsed mode the line gives a short pulse at every terminal count, whatever the state of the flag. Any inversion needed for an open-drain pin is done outside the block. The tick enables come from an external prescaler, and each is one system clock wide.

Top module: `tmr_countdown`

## Requirements
- R1: After reset, `flag` and `irq` are 0 and the timer is stopped.
- R2: A configuration write with `cfg_en`=1 while the timer is stopped loads the counter with the stored n. Counting then starts only after the first `tick_64` pulse in a later cycle. Source ticks that arrive before that pulse are ignored.
- R3: Once counting has started, the n-th selected source tick is the terminal count. `flag` reads 1 in the cycle after that tick.
- R4: At each terminal count the counter reloads automatically, so every later period is exactly n selected source ticks.
- R5: Only the `src_tick` bit whose index equals the stored `cfg_sel` value (0 to NSRC-1) advances the counter. Pulses on the other bits have no effect.
- R6: `flag` stays 1 until a `flag_clr` pulse. If `flag_clr` and a terminal count fall in the same cycle, `flag` stays 1.
- R7: While the stored interrupt enable is 0, `irq` is 0 whatever the flag.
- R8: In level mode (stored `cfg_mode`=0) with interrupts enabled, `irq` equals `flag`.
- R9: In pulsed mode (stored `cfg_mode`=1) with interrupts enabled, `irq` rises in the cycle after a terminal count. It falls after the first later `tick_64` pulse. This happens at every terminal count, whether or not `flag` has been cleared.
- R10: A write of n while the timer runs does not change the current period. It takes effect at the next reload.
- R11: With n=0, no terminal count ever occurs and `flag` stays 0.
- R12: A configuration write with `cfg_en`=0 stops counting. A later enable reloads n and waits again for a `tick_64` pulse before counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_64 | input | 1 | One-cycle 64 Hz alignment tick enable |
| src_tick | input | NSRC | One-cycle source tick enables, one bit per selectable rate |
| cfg_wr | input | 1 | Strobe that stores cfg_en, cfg_ie, cfg_mode and cfg_sel |
| cfg_en | input | 1 | Timer enable |
| cfg_ie | input | 1 | Interrupt enable |
| cfg_mode | input | 1 | Interrupt mode: 0 level, 1 pulsed |
| cfg_sel | input | SELW | Index of the source tick line |
| n_wr | input | 1 | Strobe that stores n_val |
| n_val | input | CW | Countdown value n |
| flag_clr | input | 1 | Clears the timer flag |
| flag | output | 1 | Sticky timer flag |
| irq | output | 1 | Active-high interrupt |

## Verification
The hardest case to reach is a terminal count that lands in the same cycle as a flag clear. The bench counts the selected ticks itself, takes the counter down to its last tick, and then drives that tick together with `flag_clr` in one cycle. Just as delicate is a write of n in the middle of a period. The bench writes the new value after one tick of a running period. It then checks that the current period still ends on the old count, and that the following period uses the new one.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic {
    IRQ_LEVEL = 1'b0,
    IRQ_PULSE = 1'b1
  } irq_mode_e;
endpackage

// File: rtl/tmr_arm.sv
module tmr_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic start,
  input  logic tick_64,
  output logic armed
);
  always_ff @(posedge clk) begin
    if (!rst_n)              armed <= 1'b0;
    else if (!en || start)   armed <= 1'b0;
    else if (tick_64)        armed <= 1'b1;
  end

  // R12
  disarm_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !armed);
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          dec,
  input  logic [CW-1:0] n_reg,
  output logic          term
);
  logic [CW-1:0] cnt;

  function automatic logic hits_end(input logic [CW-1:0] c);
    return c == CW'(1);
  endfunction

  function automatic logic [CW-1:0] next_count(input logic [CW-1:0] c,
                                               input logic [CW-1:0] n);
    if (c <= CW'(1)) return n;
    return c - CW'(1);
  endfunction

  assign term = dec && hits_end(cnt);

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (start) cnt <= n_reg;
    else if (dec)   cnt <= next_count(cnt, n_reg);
  end

  // R4
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    term |=> cnt == $past(n_reg));
  // R3
  step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && cnt > CW'(1)) |=> cnt == $past(cnt) - CW'(1));
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq
  import tmr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      term,
  input  logic      flag_clr,
  input  logic      tick_64,
  input  logic      ie,
  input  irq_mode_e mode,
  output logic      flag,
  output logic      irq
);
  logic pulse;

  always_ff @(posedge clk) begin
    if (!rst_n)        flag <= 1'b0;
    else if (term)     flag <= 1'b1;
    else if (flag_clr) flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       pulse <= 1'b0;
    else if (term)    pulse <= 1'b1;
    else if (tick_64) pulse <= 1'b0;
  end

  assign irq = ie && ((mode == IRQ_PULSE) ? pulse : flag);

  // R6
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !flag_clr) |=> flag);
  // R3
  term_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    term |=> flag);
endmodule

// File: rtl/tmr_countdown.sv
module tmr_countdown
  import tmr_pkg::*;
#(
  parameter int CW   = 8,
  parameter int NSRC = 4,
  localparam int SELW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_64,
  input  logic [NSRC-1:0] src_tick,
  input  logic            cfg_wr,
  input  logic            cfg_en,
  input  logic            cfg_ie,
  input  logic            cfg_mode,
  input  logic [SELW-1:0] cfg_sel,
  input  logic            n_wr,
  input  logic [CW-1:0]   n_val,
  input  logic            flag_clr,
  output logic            flag,
  output logic            irq
);
  logic            en_q, ie_q;
  irq_mode_e       mode_q;
  logic [SELW-1:0] sel_q;
  logic [CW-1:0]   n_reg;
  logic            start, armed, src_hit, dec, term;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      ie_q   <= 1'b0;
      mode_q <= IRQ_LEVEL;
      sel_q  <= '0;
    end else if (cfg_wr) begin
      en_q   <= cfg_en;
      ie_q   <= cfg_ie;
      mode_q <= irq_mode_e'(cfg_mode);
      sel_q  <= cfg_sel;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    n_reg <= '0;
    else if (n_wr) n_reg <= n_val;
  end

  assign start = cfg_wr && cfg_en && !en_q;

  always_comb begin
    src_hit = 1'b0;
    for (int i = 0; i < NSRC; i++)
      if (sel_q == SELW'(i)) src_hit = src_tick[i];
  end

  assign dec = en_q && armed && src_hit;

  tmr_arm u_arm (
    .clk(clk), .rst_n(rst_n), .en(en_q), .start(start),
    .tick_64(tick_64), .armed(armed)
  );

  tmr_count #(.CW(CW)) u_count (
    .clk(clk), .rst_n(rst_n), .start(start), .dec(dec),
    .n_reg(n_reg), .term(term)
  );

  tmr_irq u_irq (
    .clk(clk), .rst_n(rst_n), .term(term), .flag_clr(flag_clr),
    .tick_64(tick_64), .ie(ie_q), .mode(mode_q), .flag(flag), .irq(irq)
  );

  // R2
  no_count_unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !term);
endmodule

// File: tb/sim_tmr_countdown.sv
module sim_tmr_countdown;
  localparam int CW = 8;
  localparam int NSRC = 4;
  localparam int SELW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_64 = 1'b0;
  logic [NSRC-1:0] src_tick = '0;
  logic cfg_wr = 1'b0, cfg_en = 1'b0, cfg_ie = 1'b0, cfg_mode = 1'b0;
  logic [SELW-1:0] cfg_sel = '0;
  logic n_wr = 1'b0;
  logic [CW-1:0] n_val = '0;
  logic flag_clr = 1'b0;
  logic flag, irq;
  int checks = 0;
  int fails = 0;
  logic [SELW-1:0] cur_sel = '0;

  always #10 clk = ~clk;

  tmr_countdown #(.CW(CW), .NSRC(NSRC)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_64(tick_64), .src_tick(src_tick),
    .cfg_wr(cfg_wr), .cfg_en(cfg_en), .cfg_ie(cfg_ie), .cfg_mode(cfg_mode),
    .cfg_sel(cfg_sel), .n_wr(n_wr), .n_val(n_val), .flag_clr(flag_clr),
    .flag(flag), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one clock: inputs already set are sampled at the edge, then cleared
  task automatic cyc();
    @(posedge clk); #1;
    tick_64 = 1'b0; src_tick = '0; cfg_wr = 1'b0; n_wr = 1'b0; flag_clr = 1'b0;
  endtask

  task automatic write_n(input logic [CW-1:0] v);
    n_wr = 1'b1; n_val = v; cyc();
  endtask

  task automatic write_cfg(input logic en, input logic ie, input logic md, input logic [SELW-1:0] s);
    cfg_wr = 1'b1; cfg_en = en; cfg_ie = ie; cfg_mode = md; cfg_sel = s;
    if (en) cur_sel = s;
    cyc();
  endtask

  task automatic align();
    tick_64 = 1'b1; cyc();
  endtask

  task automatic ticks(input int k);
    for (int i = 0; i < k; i++) begin
      src_tick = NSRC'(1) << cur_sel; cyc();
    end
  endtask

  task automatic idle();
    cfg_wr = 1'b1; cfg_en = 1'b0; cfg_ie = 1'b0; cfg_mode = 1'b0; flag_clr = 1'b1;
    cyc();
  endtask

  task automatic t_reset();
    chk("R1 flag after reset", flag, 0);
    chk("R1 irq after reset", irq, 0);
    ticks(3);
    chk("R1 stopped after reset", flag, 0);
  endtask

  task automatic t_align();
    write_n(1); write_cfg(1, 1, 0, 0);
    ticks(2);
    chk("R2 ticks before alignment ignored", flag, 0);
    align(); ticks(1);
    chk("R2 counts after alignment", flag, 1);
    idle();
  endtask

  task automatic t_count_reload();
    write_n(3); write_cfg(1, 1, 0, 1); align();
    ticks(2);
    chk("R3 no flag before nth tick", flag, 0);
    ticks(1);
    chk("R3 flag on nth tick", flag, 1);
    chk("R8 level irq follows flag", irq, 1);
    flag_clr = 1'b1; cyc();
    chk("R8 level irq drops with flag", irq, 0);
    ticks(2);
    chk("R4 second period not early", flag, 0);
    ticks(1);
    chk("R4 second period exactly n", flag, 1);
    idle();
  endtask

  task automatic t_select();
    write_n(2); write_cfg(1, 0, 0, 2); align();
    for (int i = 0; i < 3; i++) begin
      src_tick = 4'b1011; cyc();
    end
    chk("R5 other lines ignored", flag, 0);
    ticks(1);
    chk("R5 one selected tick", flag, 0);
    ticks(1);
    chk("R5 selected line counts", flag, 1);
    idle();
  endtask

  task automatic t_sticky();
    write_n(2); write_cfg(1, 0, 0, 0); align(); ticks(2);
    cyc(); cyc(); cyc();
    chk("R6 flag holds", flag, 1);
    chk("R7 irq off when disabled", irq, 0);
    flag_clr = 1'b1; cyc();
    chk("R6 clear removes flag", flag, 0);
    ticks(1);
    flag_clr = 1'b1; src_tick = NSRC'(1) << cur_sel; cyc();
    chk("R6 set wins over clear", flag, 1);
    idle();
  endtask

  task automatic t_pulse();
    write_n(2); write_cfg(1, 1, 1, 3); align(); ticks(2);
    chk("R9 pulse rises", irq, 1);
    cyc();
    chk("R9 pulse held until 64 Hz tick", irq, 1);
    align();
    chk("R9 pulse ends after 64 Hz tick", irq, 0);
    chk("R9 flag still set", flag, 1);
    ticks(2);
    chk("R9 pulse repeats without clear", irq, 1);
    idle();
  endtask

  task automatic t_new_n();
    write_n(3); write_cfg(1, 0, 0, 0); align(); ticks(1);
    write_n(5);
    ticks(2);
    chk("R10 current period keeps old n", flag, 1);
    flag_clr = 1'b1; cyc();
    ticks(4);
    chk("R10 next period not early", flag, 0);
    ticks(1);
    chk("R10 next period uses new n", flag, 1);
    idle();
  endtask

  task automatic t_zero();
    write_n(0); write_cfg(1, 1, 0, 0); align(); ticks(6);
    chk("R11 zero count never ends", flag, 0);
    idle();
  endtask

  task automatic t_disable();
    write_n(3); write_cfg(1, 0, 0, 0); align(); ticks(2);
    write_cfg(0, 0, 0, 0);
    ticks(3);
    chk("R12 stopped while disabled", flag, 0);
    write_cfg(1, 0, 0, 0);
    ticks(3);
    chk("R12 waits for alignment again", flag, 0);
    align(); ticks(2);
    chk("R12 restart reloads n", flag, 0);
    ticks(1);
    chk("R12 full period after restart", flag, 1);
    idle();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_align();
    t_count_reload();
    t_select();
    t_sticky();
    t_pulse();
    t_new_n();
    t_zero();
    t_disable();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule